// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block arbitrates the maskable interrupt requests of a small processor core. Each source has a sticky request flag, a mask bit and a priority level in the range 0 to 3, built from one bit of a "low" priority register and one bit of a "high" priority register. Rising edges on the raw request lines set the flags, and software can also set or clear them directly. In each cycle the block picks the best pending unmasked source and, if that source may preempt the routine currently running, acknowledges it: it clears that flag, saves the previous service level on a small stack and hands the core the address of the vector table entry.

A return-from-interrupt strobe restores the saved level, so nested routines unwind in order. A software break strobe is always taken, even with interrupts globally disabled. It has a fixed vector of its own, does not take part in arbitration and leaves the service level unchanged. A separate wake output goes high whenever any unmasked flag is pending, whatever the global enable is, so the core can leave its standby states.

Top module: `vic4_ctrl`

## Requirements
- R1: A rising edge (0 then 1 on consecutive clocks) on `irq_in[i]` sets `flags[i]` at the clock edge that samples the 1. Holding the line high does not set the flag again after it has been cleared. A set mask bit does not stop the capture.
- R2: `flag_set[i]` sets `flags[i]` and `flag_clr[i]` clears it, each at the next clock edge. When both are high in the same cycle, the set wins.
- R3: The level of source i is `{prio_hi[i], prio_lo[i]}`, where 0 is the highest priority and 3 the lowest. Among the pending unmasked sources the lowest level wins. When several sources share that level, the lowest index wins.
- R4: A maskable winner is accepted only when `gie` is 1 and its level is numerically lower than `svc_lvl`. With no routine active, `svc_lvl` reads 4, so any level can be accepted.
- R5: One clock edge after a maskable acceptance, `ack` is high for exactly one cycle with `ack_brk`=0 and `ack_vec` = VEC_BASE + 2 × index. In that same cycle `svc_lvl` equals the winner's level and the winner's flag reads 0.
- R6: `reti` restores the level that was active before the most recent maskable acceptance, so nested routines unwind in order. A `reti` while `svc_lvl`=4 has no effect. No maskable request is accepted in a cycle in which `reti` is high.
- R7: `brk_req` is acknowledged at the next edge with `ack`=1, `ack_brk`=1 and `ack_vec`=BRK_VEC, regardless of `gie` and the masks. It leaves `svc_lvl` unchanged. A maskable request pending in the same cycle waits one cycle.
- R8: `wake` is 1 exactly when some flag is set whose mask bit is 0. It does not depend on `gie`.
- R9: A source whose mask bit is 1 is never acknowledged. Its flag stays pending, and it is taken once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Raw request lines, rising-edge captured |
| flag_set | input | N_SRC | Software set strobes for the request flags |
| flag_clr | input | N_SRC | Software clear strobes for the request flags |
| mask | input | N_SRC | 1 = source excluded from arbitration |
| prio_lo | input | N_SRC | Low bit of each source's priority level |
| prio_hi | input | N_SRC | High bit of each source's priority level |
| gie | input | 1 | Global enable for maskable requests |
| brk_req | input | 1 | Software break strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | output | 1 | One-cycle acknowledge to the core |
| ack_brk | output | 1 | Acknowledge is for a software break |
| ack_vec | output | 16 | Vector table address of the acknowledged entry |
| svc_lvl | output | 3 | Current in-service level (4 = idle) |
| flags | output | N_SRC | Pending request flags |
| wake | output | 1 | Standby release |

## Verification
On every cycle the assertions check properties that hold at any single acknowledge. A maskable acknowledge must follow a cycle in which `gie` was set and `reti` was low. It must lower the service level and carry an even address no lower than the table base. It must never name a source that was masked. A break acknowledge must carry the break vector and leave the level as it was. Only the bench's scenarios show the rest. That covers which source wins when levels differ or tie, the order in which nested routines unwind, edge capture versus a held line, set/clear precedence, a break arriving together with a maskable request, and the wake output, which the bench checks against the flags and masks it drives.

// File: rtl/vic4_pkg.sv
package vic4_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_IDLE = 3'd4;

    localparam int VA_W = 16;
    typedef logic [VA_W-1:0] vaddr_t;

    typedef struct packed {
        logic   valid;
        logic   brk;
        vaddr_t vec;
    } ack_t;

    function automatic vaddr_t vec_of(vaddr_t base, int unsigned idx);
        return base + vaddr_t'(idx << 1);
    endfunction
endpackage

// File: rtl/vic4_flags.sv
module vic4_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            flags <= '0;
        end else begin
            irq_q <= irq_in;
            // a set (edge or software) wins over any clear in the same cycle
            flags <= (flags & ~(sw_clr | ack_clr)) | (irq_in & ~irq_q) | sw_set;
        end
    end
endmodule

// File: rtl/vic4_arbiter.sv
module vic4_arbiter
    import vic4_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  lo,
    input  logic [N-1:0]  hi,
    output logic          any,
    output logic [IW-1:0] win_idx,
    output lvl_t          win_lvl
);
    lvl_t src_lvl [N];

    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign src_lvl[g] = {1'b0, hi[g], lo[g]};
    end

    // strict compare keeps the lowest index on a tie
    always_comb begin
        any     = 1'b0;
        win_idx = '0;
        win_lvl = LVL_IDLE;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !mask[i] && (src_lvl[i] < win_lvl)) begin
                any     = 1'b1;
                win_idx = IW'(i);
                win_lvl = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/vic4_lvlstack.sv
module vic4_lvlstack
    import vic4_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  lvl_t push_lvl,
    input  logic pop,
    output lvl_t cur_lvl
);
    localparam int SPW = $clog2(DEPTH + 1);
    localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lvl_t           stk [DEPTH];
    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_m1;

    assign sp_m1 = sp - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= '0;
            cur_lvl <= LVL_IDLE;
            for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_IDLE;
        end else if (pop && (sp != '0)) begin
            sp      <= sp_m1;
            cur_lvl <= stk[sp_m1[IXW-1:0]];
        end else if (push && (sp != SPW'(DEPTH))) begin
            stk[sp[IXW-1:0]] <= cur_lvl;
            sp               <= sp + 1'b1;
            cur_lvl          <= push_lvl;
        end
    end
endmodule

// File: rtl/vic4_ctrl.sv
module vic4_ctrl
    import vic4_pkg::*;
#(
    parameter int     N_SRC       = 8,
    parameter int     STACK_DEPTH = 4,
    parameter vaddr_t VEC_BASE    = 16'h0004,
    parameter vaddr_t BRK_VEC     = 16'h007E
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic [N_SRC-1:0] flag_set,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] prio_lo,
    input  logic [N_SRC-1:0] prio_hi,
    input  logic             gie,
    input  logic             brk_req,
    input  logic             reti,
    output logic             ack,
    output logic             ack_brk,
    output logic [15:0]      ack_vec,
    output logic [2:0]       svc_lvl,
    output logic [N_SRC-1:0] flags,
    output logic             wake
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic             any;
    logic [IW-1:0]    win_idx;
    lvl_t             win_lvl;
    lvl_t             cur_lvl;
    logic             take_irq;
    logic [N_SRC-1:0] ack_clr;
    ack_t             ack_q;

    vic4_flags #(.N(N_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .sw_set (flag_set),
        .sw_clr (flag_clr),
        .ack_clr(ack_clr),
        .flags  (flags)
    );

    vic4_arbiter #(.N(N_SRC), .IW(IW)) u_arb (
        .pend   (flags),
        .mask   (mask),
        .lo     (prio_lo),
        .hi     (prio_hi),
        .any    (any),
        .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    vic4_lvlstack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .push    (take_irq),
        .push_lvl(win_lvl),
        .pop     (reti),
        .cur_lvl (cur_lvl)
    );

    // break has precedence; a return in the same cycle also holds off acceptance
    always_comb begin
        take_irq = !brk_req && !reti && gie && any && (win_lvl < cur_lvl);
        ack_clr  = take_irq ? (N_SRC'(1) << win_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
        end else begin
            ack_q.valid <= brk_req | take_irq;
            ack_q.brk   <= brk_req;
            ack_q.vec   <= brk_req  ? BRK_VEC :
                           take_irq ? vec_of(VEC_BASE, 32'(win_idx)) : '0;
        end
    end

    assign ack     = ack_q.valid;
    assign ack_brk = ack_q.brk;
    assign ack_vec = ack_q.vec;
    assign svc_lvl = cur_lvl;
    assign wake    = |(flags & ~mask);
endmodule

// File: rtl/vic4_ctrl_chk.sv
module vic4_ctrl_chk #(
    parameter int          N_SRC    = 8,
    parameter logic [15:0] VEC_BASE = 16'h0004,
    parameter logic [15:0] BRK_VEC  = 16'h007E
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] mask,
    input logic             gie,
    input logic             reti,
    input logic             ack,
    input logic             ack_brk,
    input logic [15:0]      ack_vec,
    input logic [2:0]       svc_lvl
);
    logic [N_SRC-1:0] mask_q;
    logic [15:0]      off;
    logic             hit_masked;

    always_ff @(posedge clk) mask_q <= mask;

    assign off = ack_vec - VEC_BASE;

    always_comb begin
        hit_masked = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (off[15:1] == 15'(i)) hit_masked = mask_q[i];
    end

    p_gated_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_brk) |-> ($past(gie) && (svc_lvl < $past(svc_lvl))));

    p_no_accept_on_return_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_brk) |-> !$past(reti));

    p_even_vector_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_brk) |-> ((ack_vec[0] == 1'b0) && (ack_vec >= VEC_BASE)));

    p_brk_keeps_level_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_brk && !$past(reti)) |-> (ack && (ack_vec == BRK_VEC) && (svc_lvl == $past(svc_lvl))));

    p_masked_never_acked_r9: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_brk) |-> !hit_masked);

    p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
        svc_lvl <= 3'd4);
endmodule

bind vic4_ctrl vic4_ctrl_chk #(.N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .BRK_VEC(BRK_VEC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mask   (mask),
    .gie    (gie),
    .reti   (reti),
    .ack    (ack),
    .ack_brk(ack_brk),
    .ack_vec(ack_vec),
    .svc_lvl(svc_lvl)
);

// File: tb/test_vic4_ctrl.sv
`timescale 1ns/1ps
module test_vic4_ctrl;
    localparam int N = 8;
    localparam logic [15:0] BASE = 16'h0004;
    localparam logic [15:0] BRKV = 16'h007E;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] irq_in, flag_set, flag_clr, mask, prio_lo, prio_hi;
    logic gie, brk_req, reti;
    logic ack, ack_brk, wake;
    logic [15:0] ack_vec;
    logic [2:0] svc_lvl;
    logic [N-1:0] flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vic4_ctrl #(.N_SRC(N), .STACK_DEPTH(4), .VEC_BASE(BASE), .BRK_VEC(BRKV)) i_vic4_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .flag_set(flag_set), .flag_clr(flag_clr),
        .mask(mask), .prio_lo(prio_lo), .prio_hi(prio_hi), .gie(gie), .brk_req(brk_req),
        .reti(reti), .ack(ack), .ack_brk(ack_brk), .ack_vec(ack_vec), .svc_lvl(svc_lvl),
        .flags(flags), .wake(wake)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] lvl_of(int k);
        return 2'((k * 5 + 2) % 4);
    endfunction

    task automatic set_level_table();
        for (int k = 0; k < N; k++) begin
            prio_lo[k] = lvl_of(k)[0];
            prio_hi[k] = lvl_of(k)[1];
        end
    endtask

    task automatic pulse_set(input logic [N-1:0] v);
        flag_set = v; @(negedge clk); flag_set = '0;
    endtask
    task automatic pulse_clr(input logic [N-1:0] v);
        flag_clr = v; @(negedge clk); flag_clr = '0;
    endtask
    task automatic do_reti();
        reti = 1'b1; @(negedge clk); reti = 1'b0;
    endtask

    task automatic expect_ack(input int idx, input string req);
        @(negedge clk);
        chk(ack && !ack_brk && ack_vec == BASE + 16'(2 * idx), req, {ack, ack_brk, 14'd0, ack_vec},
            {2'b10, 14'd0, BASE + 16'(2 * idx)});
    endtask

    task automatic expect_quiet(input int cyc, input string req);
        bit seen = 1'b0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; irq_in = '0; flag_set = '0; flag_clr = '0; mask = '0;
        prio_lo = '0; prio_hi = '0; gie = 1'b0; brk_req = 1'b0; reti = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ack && svc_lvl == 3'd4 && flags == '0 && !wake, "reset", {ack, svc_lvl, flags}, {1'b0, 3'd4, 8'd0});

        // R4 R5: every source at every level, idle accepts all
        gie = 1'b1;
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 4; l++) begin
                prio_lo = '0; prio_hi = '0;
                prio_lo[i] = l[0]; prio_hi[i] = l[1];
                pulse_set(N'(1) << i);
                expect_ack(i, "R5 vector");
                chk(svc_lvl == 3'(l) && flags[i] == 1'b0, "R5 level/flag", {svc_lvl, flags}, {3'(l), 8'd0});
                do_reti();
                chk(svc_lvl == 3'd4, "R6 return to idle", svc_lvl, 4);
            end
        end

        // R3: all pairs, level then index order; R6 unwinding between
        set_level_table();
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                int w, o;
                w = (lvl_of(j) < lvl_of(i)) ? j : i;
                o = (w == i) ? j : i;
                pulse_set((N'(1) << i) | (N'(1) << j));
                expect_ack(w, "R3 first winner");
                do_reti();
                expect_ack(o, "R3 second winner");
                do_reti();
            end
        end

        // R3: all sources pending at once, expected service order
        pulse_set('1);
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < N; k++) begin
                if (lvl_of(k) == 2'(l)) begin
                    expect_ack(k, "R3 full sweep");
                    do_reti();
                end
            end
        end

        // R4 R6: nesting. sources 0:lvl3, 1:lvl1, 2:lvl2
        prio_lo = 8'b0000_0011; prio_hi = 8'b0000_0101;
        pulse_set(8'b001); expect_ack(0, "R4 idle accept");
        pulse_set(8'b010); expect_ack(1, "R4 preempt");
        chk(svc_lvl == 3'd1, "R4 nested level", svc_lvl, 1);
        pulse_set(8'b100); expect_quiet(3, "R4 lower level held off");
        do_reti();
        chk(svc_lvl == 3'd3, "R6 unwound level", svc_lvl, 3);
        expect_ack(2, "R6 pending taken after return");
        do_reti(); do_reti();
        chk(svc_lvl == 3'd4, "R6 back to idle", svc_lvl, 4);
        do_reti();
        chk(svc_lvl == 3'd4 && !ack, "R6 extra return ignored", svc_lvl, 4);

        // R4: gie cleared blocks; R6: reti same cycle blocks
        gie = 1'b0;
        pulse_set(8'b001); expect_quiet(3, "R4 gie off");
        chk(flags[0], "R4 flag kept", flags, 1);
        gie = 1'b1; reti = 1'b1; @(negedge clk); reti = 1'b0;
        chk(!ack, "R6 no accept with return", ack, 0);
        expect_ack(0, "R4 accept after enable");
        do_reti();

        // R7: break with gie off, during service, and with maskable pending
        gie = 1'b0;
        brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
        chk(ack && ack_brk && ack_vec == BRKV && svc_lvl == 3'd4, "R7 break gie off", ack_vec, BRKV);
        gie = 1'b1;
        pulse_set(8'b100); expect_ack(2, "R7 setup");
        brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
        chk(ack && ack_brk && svc_lvl == 3'd2, "R7 break keeps level", svc_lvl, 2);
        do_reti();
        gie = 1'b0; pulse_set(8'b010);
        gie = 1'b1; brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
        chk(ack && ack_brk, "R7 break first", {ack, ack_brk}, 3);
        expect_ack(1, "R7 maskable next");
        do_reti();

        // R9 R8: masked source and wake
        gie = 1'b0; mask = 8'b0000_1000;
        pulse_set(8'b1000);
        chk(!wake, "R8 masked no wake", wake, 0);
        gie = 1'b1; expect_quiet(3, "R9 masked not acked");
        chk(flags[3], "R9 flag kept", flags, 8);
        gie = 1'b0; mask = '0; #1;
        chk(wake, "R8 unmasked wakes with gie off", wake, 1);
        gie = 1'b1; expect_ack(3, "R9 taken when unmasked");
        chk(!wake, "R8 wake drops", wake, 0);
        do_reti();

        // R1: edge capture, held line, mask does not block capture
        gie = 1'b0; mask = 8'b0010_0000;
        irq_in[5] = 1'b1; @(negedge clk);
        chk(flags[5], "R1 edge capture masked", flags, 32);
        pulse_clr(8'b0010_0000);
        repeat (3) @(negedge clk);
        chk(!flags[5], "R1 held line no recapture", flags, 0);
        irq_in[5] = 1'b0; @(negedge clk);
        irq_in[5] = 1'b1; @(negedge clk);
        chk(flags[5], "R1 second edge", flags, 32);
        irq_in = '0;

        // R2: set/clear, set wins
        flag_clr = 8'b0010_0000; flag_set = 8'b0100_0000; @(negedge clk);
        chk(flags == 8'b0100_0000, "R2 set and clear", flags, 8'h40);
        flag_clr = 8'b0100_0000; flag_set = 8'b0100_0000; @(negedge clk);
        flag_clr = '0; flag_set = '0;
        chk(flags[6], "R2 set wins", flags, 8'h40);
        pulse_clr('1);
        chk(flags == '0, "R2 clear all", flags, 0);

        finish_run();
    end
endmodule